// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block walks a 16-bit register mask and issues one word transfer per clock between a 16-entry register file and memory. For each transfer it drives the register index, the byte address and the direction. A neighbouring decoder hands it a 32-bit operation word and the current value of the base register, then pulses `startIn`. The sequencer latches everything on that edge. It then steps through the selected registers in ascending or descending order, advancing a running address by one word each time. At the end it can offer the final running address as a writeback value for the base register.

The register file and the memory sit outside this block. The block drives only their request strobes, and it consumes no response. Two encodings are refused: a mask that names the program-counter slot (mask bit 15), and the privileged-bank flag (bit 22). Either one produces a one-cycle undefined-operation trap, and no transfer is issued.

Top module: `blkxfer_seq`

## Requirements
- R1: The operation word is decoded as follows: bit 24 = before/after step select (1 = step before each transfer), bit 23 = direction (1 = ascending), bit 22 = privileged-bank flag, bit 21 = writeback enable, bit 20 = load (1 = memory to register, 0 = register to memory), bits 19:16 = base register index, bits 15:0 = register mask. Operation word and base address are latched on a clock edge where `startIn` is high and `busy` is low.
- R2: If mask bit 15 or bit 22 is set, `trapUndef` is high for exactly the one cycle after the start edge, and in that cycle no transfer and no `done` occur.
- R3: When ascending, registers are issued in increasing index order, and each transfer address is 4 above the previous one.
- R4: When descending, registers are issued in decreasing index order, and each transfer address is 4 below the previous one.
- R5: With bit 24 set, the first address is the base plus 4 when ascending, or the base minus 4 when descending. With bit 24 clear, the first address equals the base.
- R6: `xferLoad` equals bit 20 of the latched operation word on every transfer of that operation.
- R7: When bit 21 is set, `wbValid` is high in the `done` cycle, with `wbReg` equal to the base index and `wbAddr` equal to the base plus or minus 4 times the transfer count. When bit 21 is clear, `wbValid` stays low.
- R8: Clear mask bits take no cycles. The first transfer appears in the first cycle after the start edge, transfers are issued back to back, and `done` comes in the cycle right after the last transfer.
- R9: An empty mask produces `done` in the first cycle after the start edge, with no transfer, and with the writeback address equal to the unchanged base.
- R10: A `startIn` pulse while `busy` is high has no effect on the running operation.
- R11: `done` is high for exactly one cycle, and `busy` is low in the cycle after `done` or `trapUndef`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startIn | input | 1 | Start request, honoured only when idle |
| opWord | input | 32 | Operation word (fields per R1) |
| baseAddr | input | 32 | Current value of the base register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| trapUndef | output | 1 | One-cycle undefined-operation trap |
| xferValid | output | 1 | A word transfer is requested this cycle |
| xferReg | output | 4 | Register index of the transfer |
| xferAddr | output | 32 | Byte address of the transfer |
| xferLoad | output | 1 | 1 = load into register, 0 = store to memory |
| wbValid | output | 1 | Base register writeback request |
| wbReg | output | 4 | Base register index for writeback |
| wbAddr | output | 32 | Value to write back to the base register |

## Verification
On every cycle, the assertions check the following:
- successive transfers of one operation move strictly in index order, in the latched direction, with a one-word address step;
- the direction bit holds steady across a burst;
- `done` never lasts longer than a cycle;
- a trap is always followed by idle;
- an operation stays busy until it signals completion.

Only the bench scenarios can show the properties that depend on the whole operation:
- the first address chosen under each before/after and direction combination;
- that clear mask bits cost no cycles;
- the final writeback value;
- that a start pulse arriving mid-burst leaves the burst untouched.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
  localparam int OP_W       = 32;
  localparam int MASK_W     = 16;
  localparam int POS_BEFORE = 24;
  localparam int POS_UP     = 23;
  localparam int POS_PRIV   = 22;
  localparam int POS_WB     = 21;
  localparam int POS_LOAD   = 20;
  localparam int POS_BASE   = 16;
  localparam int IDX_W      = $clog2(MASK_W);

  typedef struct packed {
    logic capture;
    logic advance;
  } seqStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TRAP = 2'd2
  } seqState_t;
endpackage

// File: rtl/blkxfer_ctrl.sv
module blkxfer_ctrl
  import blkxfer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic       illegalOp,
  input  logic       maskEmpty,
  output seqStrobe_t strb,
  output logic       busy,
  output logic       done,
  output logic       trapUndef
);
  seqState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (startIn) stateD = illegalOp ? ST_TRAP : ST_RUN;
      ST_RUN:  if (maskEmpty) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strb.capture = (stateQ == ST_IDLE) && startIn && !illegalOp;
    strb.advance = (stateQ == ST_RUN) && !maskEmpty;
    busy         = (stateQ != ST_IDLE);
    done         = (stateQ == ST_RUN) && maskEmpty;
    trapUndef    = (stateQ == ST_TRAP);
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2
  trap_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapUndef |=> !busy);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && !trapUndef) |=> busy);
endmodule

// File: rtl/blkxfer_dp.sv
module blkxfer_dp
  import blkxfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [OP_W-1:0]   opWord,
  input  logic [ADDR_W-1:0] baseAddr,
  output logic              maskEmpty,
  output logic [IDX_W-1:0]  xferReg,
  output logic [ADDR_W-1:0] xferAddr,
  output logic              xferLoad,
  output logic              wbEnable,
  output logic [IDX_W-1:0]  wbReg,
  output logic [ADDR_W-1:0] wbAddr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [MASK_W-1:0] maskQ;
  logic [ADDR_W-1:0] addrQ;
  logic              upQ, beforeQ, loadQ, wbQ;
  logic [IDX_W-1:0]  baseQ;
  logic [IDX_W-1:0]  lowIdx, highIdx;
  logic [ADDR_W-1:0] nextAddr;

  // lowest and highest set bit of the remaining mask
  always_comb begin
    lowIdx  = '0;
    highIdx = '0;
    for (int i = MASK_W - 1; i >= 0; i--)
      if (maskQ[i]) lowIdx = IDX_W'(i);
    for (int i = 0; i < MASK_W; i++)
      if (maskQ[i]) highIdx = IDX_W'(i);
  end

  assign nextAddr  = upQ ? addrQ + STEP : addrQ - STEP;
  assign maskEmpty = (maskQ == '0);
  assign xferReg   = upQ ? lowIdx : highIdx;
  assign xferAddr  = beforeQ ? nextAddr : addrQ;
  assign xferLoad  = loadQ;
  assign wbEnable  = wbQ;
  assign wbReg     = baseQ;
  assign wbAddr    = addrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ   <= '0;
      addrQ   <= '0;
      upQ     <= 1'b0;
      beforeQ <= 1'b0;
      loadQ   <= 1'b0;
      wbQ     <= 1'b0;
      baseQ   <= '0;
    end else if (strb.capture) begin
      maskQ   <= opWord[MASK_W-1:0];
      addrQ   <= baseAddr;
      upQ     <= opWord[POS_UP];
      beforeQ <= opWord[POS_BEFORE];
      loadQ   <= opWord[POS_LOAD];
      wbQ     <= opWord[POS_WB];
      baseQ   <= opWord[POS_BASE +: IDX_W];
    end else if (strb.advance) begin
      addrQ          <= nextAddr;
      maskQ[xferReg] <= 1'b0;
    end
  end

  // R3
  asc_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && $past(strb.advance) && upQ) |->
      (xferAddr == $past(xferAddr) + STEP && xferReg > $past(xferReg)));

  // R4
  desc_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && $past(strb.advance) && !upQ) |->
      (xferAddr == $past(xferAddr) - STEP && xferReg < $past(xferReg)));

  // R6
  dir_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && $past(strb.advance)) |-> $stable(xferLoad));
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [OP_W-1:0]   opWord,
  input  logic [ADDR_W-1:0] baseAddr,
  output logic              busy,
  output logic              done,
  output logic              trapUndef,
  output logic              xferValid,
  output logic [IDX_W-1:0]  xferReg,
  output logic [ADDR_W-1:0] xferAddr,
  output logic              xferLoad,
  output logic              wbValid,
  output logic [IDX_W-1:0]  wbReg,
  output logic [ADDR_W-1:0] wbAddr
);
  seqStrobe_t strb;
  logic       maskEmpty, wbEnable, illegalOp;

  // top mask slot is the program counter; bank flag is privileged
  assign illegalOp = opWord[MASK_W-1] | opWord[POS_PRIV];

  blkxfer_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startIn   (startIn),
    .illegalOp (illegalOp),
    .maskEmpty (maskEmpty),
    .strb      (strb),
    .busy      (busy),
    .done      (done),
    .trapUndef (trapUndef)
  );

  blkxfer_dp #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .opWord    (opWord),
    .baseAddr  (baseAddr),
    .maskEmpty (maskEmpty),
    .xferReg   (xferReg),
    .xferAddr  (xferAddr),
    .xferLoad  (xferLoad),
    .wbEnable  (wbEnable),
    .wbReg     (wbReg),
    .wbAddr    (wbAddr)
  );

  assign xferValid = strb.advance;
  assign wbValid   = done & wbEnable;

  // R7
  wb_in_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (done && !xferValid));
endmodule

// File: tb/blkxfer_seq_bench.sv
`timescale 1ns/1ps
module blkxfer_seq_bench;
  localparam logic [31:0] BASE = 32'h0000_1000;

  typedef struct packed {
    logic [31:0] op;
    logic [4:0]  cnt;
    logic [3:0]  fReg;
    logic [31:0] fAddr;
    logic [3:0]  lReg;
    logic [31:0] lAddr;
    logic        wb;
    logic [31:0] wbA;
    logic        ld;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{op:32'h00B30005, cnt:5'd2,  fReg:4'd0,  fAddr:32'h1000, lReg:4'd2,  lAddr:32'h1004, wb:1'b1, wbA:32'h1008, ld:1'b1},
    '{op:32'h01A100F0, cnt:5'd4,  fReg:4'd4,  fAddr:32'h1004, lReg:4'd7,  lAddr:32'h1010, wb:1'b1, wbA:32'h1010, ld:1'b0},
    '{op:32'h012D4001, cnt:5'd2,  fReg:4'd14, fAddr:32'h0FFC, lReg:4'd0,  lAddr:32'h0FF8, wb:1'b1, wbA:32'h0FF8, ld:1'b0},
    '{op:32'h00120102, cnt:5'd2,  fReg:4'd8,  fAddr:32'h1000, lReg:4'd1,  lAddr:32'h0FFC, wb:1'b0, wbA:32'h0,    ld:1'b1},
    '{op:32'h00A07FFF, cnt:5'd15, fReg:4'd0,  fAddr:32'h1000, lReg:4'd14, lAddr:32'h1038, wb:1'b1, wbA:32'h103C, ld:1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [31:0] opWord = '0;
  logic [31:0] baseAddr = BASE;
  logic        busy, done, trapUndef, xferValid, xferLoad, wbValid;
  logic [3:0]  xferReg, wbReg;
  logic [31:0] xferAddr, wbAddr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  blkxfer_seq u_blkxfer_seq (
    .clk(clk), .rstN(rstN), .startIn(startIn), .opWord(opWord),
    .baseAddr(baseAddr), .busy(busy), .done(done), .trapUndef(trapUndef),
    .xferValid(xferValid), .xferReg(xferReg), .xferAddr(xferAddr),
    .xferLoad(xferLoad), .wbValid(wbValid), .wbReg(wbReg), .wbAddr(wbAddr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // results of one run
  int          nX, doneAt, stepBad, orderBad, ldBad;
  logic [3:0]  fR, lR, wR;
  logic [31:0] fA, lA, wA;
  logic        wbSeen, trapSeen, doneSeen, doneAfter, busyAfter;

  task automatic runOp(input logic [31:0] op, input bit poke, input bit expLd);
    nX = 0; doneAt = -1; stepBad = 0; orderBad = 0; ldBad = 0;
    wbSeen = 0; trapSeen = 0; doneSeen = 0;
    fR = '0; lR = '0; fA = '0; lA = '0; wR = '0; wA = '0;
    @(negedge clk);
    opWord = op; startIn = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      startIn = poke && (k == 0);
      if (poke && k == 0) opWord = 32'h00A0000F;
      if (xferValid) begin
        if (nX == 0) begin fR = xferReg; fA = xferAddr; end
        else begin
          if (op[23]) begin
            if (xferAddr != lA + 4) stepBad++;
            if (xferReg <= lR) orderBad++;
          end else begin
            if (xferAddr != lA - 4) stepBad++;
            if (xferReg >= lR) orderBad++;
          end
        end
        if (xferLoad != expLd) ldBad++;
        lR = xferReg; lA = xferAddr; nX++;
      end
      if (wbValid) begin wbSeen = 1; wR = wbReg; wA = wbAddr; end
      if (trapUndef) trapSeen = 1;
      if (done) begin doneSeen = 1; doneAt = k; end
      if (done || trapUndef) break;
    end
    startIn = 1'b0;
    @(negedge clk);
    doneAfter = done; busyAfter = busy;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // reset state
    repeat (2) @(negedge clk);
    chk("reset busy", {31'b0, busy}, 32'd0);
    chk("reset done", {31'b0, done}, 32'd0);
    chk("reset xferValid", {31'b0, xferValid}, 32'd0);
    chk("reset trap", {31'b0, trapUndef}, 32'd0);
    rstN = 1'b1;

    // table walk: R1 R3 R4 R5 R6 R7 R8 R11
    for (int v = 0; v < NV; v++) begin
      runOp(VECS[v].op, 1'b0, VECS[v].ld);
      chk("R8 transfer count", nX, 32'(VECS[v].cnt));
      chk("R8 done right after last transfer", doneAt, 32'(VECS[v].cnt));
      chk("R5 first reg", {28'b0, fR}, {28'b0, VECS[v].fReg});
      chk("R5 first addr", fA, VECS[v].fAddr);
      chk("R3 R4 last reg", {28'b0, lR}, {28'b0, VECS[v].lReg});
      chk("R3 R4 last addr", lA, VECS[v].lAddr);
      chk("R3 R4 step", stepBad, 0);
      chk("R3 R4 order", orderBad, 0);
      chk("R6 direction", ldBad, 0);
      chk("R7 wb valid", {31'b0, wbSeen}, {31'b0, VECS[v].wb});
      if (VECS[v].wb) begin
        chk("R7 wb addr", wA, VECS[v].wbA);
        chk("R1 R7 wb reg", {28'b0, wR}, {28'b0, VECS[v].op[19:16]});
      end
      chk("R11 done one cycle", {31'b0, doneAfter}, 32'd0);
      chk("R11 idle after done", {31'b0, busyAfter}, 32'd0);
    end

    // R9 empty mask, writeback of unchanged base
    runOp(32'h00A50000, 1'b0, 1'b0);
    chk("R9 no transfers", nX, 0);
    chk("R9 done first cycle", doneAt, 0);
    chk("R9 wb addr", wA, BASE);
    chk("R9 wb reg", {28'b0, wR}, 32'd5);

    // R2 mask bit 15
    runOp(32'h00808001, 1'b0, 1'b0);
    chk("R2 trap on pc slot", {31'b0, trapSeen}, 32'd1);
    chk("R2 no transfer on trap", nX, 0);
    chk("R2 no done on trap", {31'b0, doneSeen}, 32'd0);
    chk("R11 idle after trap", {31'b0, busyAfter}, 32'd0);

    // R2 privileged bank flag
    runOp(32'h00C00001, 1'b0, 1'b0);
    chk("R2 trap on bank flag", {31'b0, trapSeen}, 32'd1);
    chk("R2 no transfer on bank flag", nX, 0);

    // R10 start mid-burst is ignored
    runOp(32'h01A100F0, 1'b1, 1'b0);
    chk("R10 count unchanged", nX, 4);
    chk("R10 last reg unchanged", {28'b0, lR}, 32'd7);
    chk("R10 wb addr unchanged", wA, 32'h1010);
    chk("R10 idle afterwards", {31'b0, busyAfter}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule